// File: doc/BRIEF.md
# Programmed I/O and Configuration Transaction Controller

This block lets software issue single bus transactions, one at a time, to two separate spaces of an external bus: the I/O space and the configuration space. Each space has its own register set. Software fills in an address register and, for a write, a data register. It then writes a control register, which selects the direction and the byte lanes and starts the transaction at once. The bus itself is outside this block. It is reached through a request that is held high until the far side pulses a done strobe.

The two spaces share one bus path, so they exclude each other. While either space has a transaction outstanding, an attempt to start another is refused and the refusal is recorded. On completion, a read result is stored in the data register of its space and a sticky done flag is set. Software can poll the flags or enable them as interrupt sources. The flags are cleared by writing one to them.

Top module: `pio_xact_ctrl`

## Requirements
- R1: After reset, bus_req and irq are low and every register reads as zero.
- R2: Register offsets are I/O address 0x0, I/O data 0x1, I/O control 0x2, configuration address 0x4, configuration data 0x5 and configuration control 0x6. A read returns the value on rd_data in the cycle after rd_en. In a control word, bit 0 is the direction (1 = write) and bits 7:4 are the byte enables. An accepted control write drives the following on the next cycle: bus_req high, bus_space (0 = I/O, 1 = configuration), bus_write, bus_be, and the stored address and data of that space.
- R3: bus_req and all bus command outputs hold steady until bus_done is sampled high. bus_req is low in the following cycle.
- R4: When a read completes, bus_rdata is stored into the data register of that space on the same clock edge that sets its done flag.
- R5: The status word at offset 0x8 has these bits: 0 I/O done, 1 configuration done, 2 I/O refused, 3 configuration refused, 4 I/O busy, 5 configuration busy. Writing 1 to any of bits 0 to 3 clears that bit.
- R6: A control write of either space is refused while any transaction is outstanding. A refused write sets the refused bit of the space that was written, starts nothing, and leaves the outstanding transaction unchanged.
- R7: The two spaces are never busy at the same time. After a completion, the other space can start a transaction.
- R8: irq goes high one cycle after any status bit 0 to 3 is set while its enable bit at offset 0x9 (same bit positions) is also set. irq goes low one cycle after no such pair remains.
- R9: Writes to the address or data register of a space are ignored while that space is busy.
- R10: A bus_done pulse while bus_req is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 32 | Register write value |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 32 | Registered read value |
| bus_req | output | 1 | Transaction request, held until done |
| bus_space | output | 1 | 0 = I/O, 1 = configuration |
| bus_write | output | 1 | 1 = write transaction |
| bus_addr | output | 32 | Transaction address |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte lane enables |
| bus_done | input | 1 | Completion strobe from the bus |
| bus_rdata | input | 32 | Read data, valid with bus_done |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The hardest case to reach is a collision: a control write for one space, or a second control write for the same space, that arrives while a transaction is still outstanding. Register writes to the busy space must be made in the same window. To create that window, the bench bus responder holds back bus_done for sixteen cycles on one chosen transaction. During those cycles the driver writes the other control register, the own control register and the own address register. The responder checks each cycle that the bus command stays unchanged. Afterwards the status word and the address readback show what was refused and what was kept.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_AW = 4;
  localparam int NSPACE = 2;
  localparam int SP_IO  = 0;
  localparam int SP_CFG = 1;

  localparam logic [REG_AW-1:0] OFS_IO_ADDR = 4'h0;
  localparam logic [REG_AW-1:0] OFS_IO_DATA = 4'h1;
  localparam logic [REG_AW-1:0] OFS_IO_CTRL = 4'h2;
  localparam logic [REG_AW-1:0] OFS_CF_ADDR = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CF_DATA = 4'h5;
  localparam logic [REG_AW-1:0] OFS_CF_CTRL = 4'h6;
  localparam logic [REG_AW-1:0] OFS_STATUS  = 4'h8;
  localparam logic [REG_AW-1:0] OFS_IRQ_EN  = 4'h9;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_BE_LSB  = 4;
  localparam int NSTS         = 4;
endpackage

// File: rtl/pio_chan.sv
module pio_chan #(
  parameter int W = 32,
  localparam int BE_W = W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_we,
  input  logic            data_we,
  input  logic            ctrl_we,
  input  logic [W-1:0]    wdata,
  input  logic            dir_in,
  input  logic [BE_W-1:0] be_in,
  input  logic            other_busy,
  input  logic            complete,
  input  logic [W-1:0]    bus_rdata,
  input  logic            clr_done,
  input  logic            clr_rej,
  output logic [W-1:0]    addr_q,
  output logic [W-1:0]    data_q,
  output logic            dir_q,
  output logic [BE_W-1:0] be_q,
  output logic            busy_q,
  output logic            launch,
  output logic            done_q,
  output logic            rej_q
);
  logic refuse;

  assign launch = ctrl_we & ~busy_q & ~other_busy;
  assign refuse = ctrl_we & ~launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      dir_q  <= 1'b0;
      be_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      if (addr_we && !busy_q) addr_q <= wdata;
      if (complete && !dir_q) data_q <= bus_rdata;
      else if (data_we && !busy_q) data_q <= wdata;
      if (launch) begin
        dir_q <= dir_in;
        be_q  <= be_in;
      end
      if (launch) busy_q <= 1'b1;
      else if (complete) busy_q <= 1'b0;
      if (complete) done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (refuse) rej_q <= 1'b1;
      else if (clr_rej) rej_q <= 1'b0;
    end
  end

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(complete));
  // R10
  cmpl_busy_chk: assert property (@(posedge clk) disable iff (rst)
    complete |-> busy_q);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(addr_q));
  // R4
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(complete));
endmodule

// File: rtl/pio_bus_port.sv
module pio_bus_port #(
  parameter int W = 32,
  parameter int NSP = 2,
  localparam int BE_W = W / 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSP-1:0]        launch,
  input  logic                  dir_in,
  input  logic [BE_W-1:0]       be_in,
  input  logic [NSP-1:0][W-1:0] addr_in,
  input  logic [NSP-1:0][W-1:0] data_in,
  input  logic                  bus_done,
  output logic                  bus_req,
  output logic                  bus_space,
  output logic                  bus_write,
  output logic [W-1:0]          bus_addr,
  output logic [W-1:0]          bus_wdata,
  output logic [BE_W-1:0]       bus_be,
  output logic [NSP-1:0]        complete
);
  logic sel;
  assign sel = launch[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_space <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_be    <= '0;
    end else if (|launch) begin
      bus_req   <= 1'b1;
      bus_space <= sel;
      bus_write <= dir_in;
      bus_addr  <= addr_in[sel];
      bus_wdata <= data_in[sel];
      bus_be    <= be_in;
    end else if (bus_done) begin
      bus_req <= 1'b0;
    end
  end

  for (genvar i = 0; i < NSP; i++) begin : g_cmpl
    assign complete[i] = bus_done & bus_req & (bus_space == i[0]);
  end

  // R7
  one_launch_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(launch));
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_space)
                             && $stable(bus_be) && $stable(bus_wdata));
  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_done |=> !bus_req);
endmodule

// File: rtl/pio_xact_ctrl.sv
module pio_xact_ctrl
  import pio_pkg::*;
#(
  parameter int W = 32,
  localparam int BE_W = W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              bus_req,
  output logic              bus_space,
  output logic              bus_write,
  output logic [W-1:0]      bus_addr,
  output logic [W-1:0]      bus_wdata,
  output logic [BE_W-1:0]   bus_be,
  input  logic              bus_done,
  input  logic [W-1:0]      bus_rdata,
  output logic              irq
);
  logic [NSPACE-1:0]        addr_we, data_we, ctrl_we;
  logic [NSPACE-1:0]        launch, busy, done, rej, complete;
  logic [NSPACE-1:0][W-1:0] addr_r, data_r;
  logic [NSPACE-1:0]        dir_r;
  logic [NSPACE-1:0][BE_W-1:0] be_r;
  logic [NSTS-1:0]          sts, irq_en, clr;
  logic                     sts_we;

  always_comb begin
    addr_we = '0;
    data_we = '0;
    ctrl_we = '0;
    sts_we  = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        OFS_IO_ADDR: addr_we[SP_IO]  = 1'b1;
        OFS_IO_DATA: data_we[SP_IO]  = 1'b1;
        OFS_IO_CTRL: ctrl_we[SP_IO]  = 1'b1;
        OFS_CF_ADDR: addr_we[SP_CFG] = 1'b1;
        OFS_CF_DATA: data_we[SP_CFG] = 1'b1;
        OFS_CF_CTRL: ctrl_we[SP_CFG] = 1'b1;
        OFS_STATUS:  sts_we          = 1'b1;
        default: ;
      endcase
    end
  end

  assign clr = sts_we ? wr_data[NSTS-1:0] : '0;

  for (genvar s = 0; s < NSPACE; s++) begin : g_sp
    pio_chan #(.W(W)) u_chan (
      .clk(clk), .rst(rst),
      .addr_we(addr_we[s]), .data_we(data_we[s]), .ctrl_we(ctrl_we[s]),
      .wdata(wr_data),
      .dir_in(wr_data[CTRL_DIR_BIT]),
      .be_in(wr_data[CTRL_BE_LSB +: BE_W]),
      .other_busy(busy[NSPACE-1-s]),
      .complete(complete[s]),
      .bus_rdata(bus_rdata),
      .clr_done(clr[s]),
      .clr_rej(clr[NSPACE + s]),
      .addr_q(addr_r[s]), .data_q(data_r[s]),
      .dir_q(dir_r[s]), .be_q(be_r[s]),
      .busy_q(busy[s]), .launch(launch[s]),
      .done_q(done[s]), .rej_q(rej[s])
    );
  end

  pio_bus_port #(.W(W), .NSP(NSPACE)) u_port (
    .clk(clk), .rst(rst),
    .launch(launch),
    .dir_in(wr_data[CTRL_DIR_BIT]),
    .be_in(wr_data[CTRL_BE_LSB +: BE_W]),
    .addr_in(addr_r), .data_in(data_r),
    .bus_done(bus_done),
    .bus_req(bus_req), .bus_space(bus_space), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .complete(complete)
  );

  assign sts = {rej, done};

  function automatic logic [W-1:0] ctrl_word(input logic d, input logic [BE_W-1:0] b);
    logic [W-1:0] v;
    v = '0;
    v[CTRL_DIR_BIT] = d;
    v[CTRL_BE_LSB +: BE_W] = b;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en  <= '0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr == OFS_IRQ_EN) irq_en <= wr_data[NSTS-1:0];
      irq <= |(sts & irq_en);
      if (rd_en) begin
        case (rd_addr)
          OFS_IO_ADDR: rd_data <= addr_r[SP_IO];
          OFS_IO_DATA: rd_data <= data_r[SP_IO];
          OFS_IO_CTRL: rd_data <= ctrl_word(dir_r[SP_IO], be_r[SP_IO]);
          OFS_CF_ADDR: rd_data <= addr_r[SP_CFG];
          OFS_CF_DATA: rd_data <= data_r[SP_CFG];
          OFS_CF_CTRL: rd_data <= ctrl_word(dir_r[SP_CFG], be_r[SP_CFG]);
          OFS_STATUS:  rd_data <= W'({busy, sts});
          OFS_IRQ_EN:  rd_data <= W'(irq_en);
          default:     rd_data <= '0;
        endcase
      end
    end
  end

  // R7
  excl_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy[SP_IO] && busy[SP_CFG]));
  // R2
  req_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req == (|busy));
  // R6
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (|ctrl_we) && (|busy) |=> $stable(busy) && $stable(bus_addr));
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(sts & irq_en)));
  // R10
  stray_done_chk: assert property (@(posedge clk) disable iff (rst)
    bus_done && !bus_req && !wr_en |=> $stable(sts) && $stable(busy));
endmodule

// File: tb/tb_pio_xact_ctrl.sv
module tb_pio_xact_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        bus_req, bus_space, bus_write, irq;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_done = 0;
  logic [31:0] bus_rdata = 0;

  always #2.5 clk = ~clk;

  pio_xact_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_req(bus_req), .bus_space(bus_space), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic sp; logic wr; logic [31:0] addr; logic [31:0] data;
    logic [3:0] be; logic [31:0] rdata; int delay;
  } item_t;
  item_t exp_q[$];

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic push(logic sp, logic wr_, logic [31:0] a, logic [31:0] d,
                      logic [3:0] be, logic [31:0] rdv, int dly);
    item_t it;
    it.sp = sp; it.wr = wr_; it.addr = a; it.data = d; it.be = be;
    it.rdata = rdv; it.delay = dly;
    exp_q.push_back(it);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (bus_req);
    @(negedge clk);
  endtask

  // monitor and bus responder
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (bus_req && !rst) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected request", 32'd1, 32'd0);
          it.delay = 1; it.rdata = 0; it.wr = 1;
          it.sp = bus_space; it.addr = bus_addr; it.data = bus_wdata; it.be = bus_be;
        end else begin
          it = exp_q.pop_front();
          chk("R2 space", 32'(bus_space), 32'(it.sp));
          chk("R2 write", 32'(bus_write), 32'(it.wr));
          chk("R2 addr", bus_addr, it.addr);
          chk("R2 be", 32'(bus_be), 32'(it.be));
          if (it.wr) chk("R2 wdata", bus_wdata, it.data);
        end
        for (int k = 0; k < it.delay; k++) begin
          @(negedge clk);
          if (bus_req !== 1'b1 || bus_addr !== it.addr)
            chk("R3 hold", {bus_req, bus_addr[30:0]}, {1'b1, it.addr[30:0]});
        end
        bus_done = 1; bus_rdata = it.rdata;
        @(negedge clk);
        bus_done = 0; bus_rdata = 0;
        chk("R3 drop", 32'(bus_req), 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(4'h8, v); chk("R1 status", v, 0);
    rd(4'h0, v); chk("R1 io addr", v, 0);
    rd(4'h5, v); chk("R1 cfg data", v, 0);

    // R2 register readback and I/O write launch
    wr(4'h0, 32'h1000_0040);
    rd(4'h0, v); chk("R2 io addr readback", v, 32'h1000_0040);
    wr(4'h1, 32'hA5A5_0001);
    push(0, 1, 32'h1000_0040, 32'hA5A5_0001, 4'h3, 0, 3);
    wr(4'h2, 32'h31);
    chk("R2 req next cycle", 32'(bus_req), 1);
    wait_idle();
    rd(4'h2, v); chk("R2 io ctrl readback", v, 32'h31);
    rd(4'h8, v); chk("R5 io done", v, 32'h1);
    wr(4'h8, 32'h1);
    rd(4'h8, v); chk("R5 w1c", v, 0);

    // R4 configuration read
    wr(4'h4, 32'h8000_0010);
    push(1, 0, 32'h8000_0010, 0, 4'hF, 32'hDEAD_BEEF, 2);
    wr(4'h6, 32'hF0);
    wait_idle();
    rd(4'h5, v); chk("R4 read capture", v, 32'hDEAD_BEEF);
    rd(4'h8, v); chk("R5 cfg done", v, 32'h2);

    // R8 interrupt
    chk("R8 irq off when disabled", 32'(irq), 0);
    wr(4'h9, 32'h3);
    @(negedge clk);
    chk("R8 irq on", 32'(irq), 1);
    wr(4'h8, 32'h2);
    @(negedge clk);
    chk("R8 irq off after clear", 32'(irq), 0);

    // R6 / R9 collision window
    wr(4'h0, 32'h0000_2000);
    wr(4'h1, 32'h1111_2222);
    push(0, 1, 32'h0000_2000, 32'h1111_2222, 4'hF, 0, 16);
    wr(4'h2, 32'hF1);
    wr(4'h6, 32'h10);
    rd(4'h8, v); chk("R6 cfg refused while io busy", v, 32'h18);
    wr(4'h0, 32'h0000_3333);
    wr(4'h2, 32'h11);
    rd(4'h8, v); chk("R6 io refused while io busy", v, 32'h1C);
    rd(4'h0, v); chk("R9 addr write ignored", v, 32'h0000_2000);
    wait_idle();
    rd(4'h8, v); chk("R6 status after completion", v, 32'h0D);
    chk("R8 irq io done", 32'(irq), 1);

    // R10 stray done
    @(negedge clk); bus_done = 1;
    @(negedge clk); bus_done = 0;
    rd(4'h8, v); chk("R10 status unchanged", v, 32'h0D);
    chk("R10 no request", 32'(bus_req), 0);

    // R7 other space usable after completion
    wr(4'h8, 32'hF);
    wr(4'h4, 32'h0000_0044);
    wr(4'h5, 32'h5555_AAAA);
    push(1, 1, 32'h0000_0044, 32'h5555_AAAA, 4'h5, 0, 1);
    wr(4'h6, 32'h51);
    wait_idle();
    rd(4'h8, v); chk("R7 cfg after io", v, 32'h2);
    chk("R2 all expected seen", exp_q.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule